// File: doc/BRIEF.md
# Root Port Error Message Collector

This block sits at a root port and gathers the error messages forwarded to it. Each message has one of three severities (correctable, non-fatal, fatal) and a 16-bit requester ID. The block keeps a set of sticky received flags in a 32-bit root error status word. It captures the requester ID of the first correctable error and of the first uncorrectable error in a 32-bit error source word. It also holds a three-bit root error command that enables notification for each severity.

Notification leaves the block in one of two ways. When `msi_enable_i` is low, `irq_level_o` is a level line. When `msi_enable_i` is high, `irq_pulse_o` gives a one-cycle pulse. The pulse fires only when an enabled severity newly appears and no enabled severity was already latched. Software reaches the block through one write port. That port either clears status bits with write-one-to-clear or loads the command.

Top module: `root_err_collector`

## Requirements
- R1: While `rst_ni` is low, `root_status_o`, `err_src_o`, `root_cmd_o`, `irq_level_o` and `irq_pulse_o` are all zero.
- R2: Severity codes are 0 correctable, 1 non-fatal and 2 fatal. On a correctable message with status bit 0 (correctable received) clear, `err_src_o[15:0]` takes the message ID. If bit 0 is already set, bit 1 (multiple correctable) is set and `err_src_o[15:0]` is kept. In both cases bit 0 ends set.
- R3: A non-fatal message sets status bit 5 (non-fatal received).
- R4: A fatal message sets status bit 6 (fatal received). It sets bit 4 (first fatal) only if bit 2 (uncorrectable received) was clear before the message. Otherwise bit 4 keeps its value.
- R5: On a non-fatal or fatal message with bit 2 clear, `err_src_o[31:16]` takes the message ID. If bit 2 is already set, bit 3 (multiple uncorrectable) is set and `err_src_o[31:16]` is kept. In both cases bit 2 ends set.
- R6: In message mode, `irq_pulse_o` is high for the one cycle after a message when two conditions hold. The command enables that message's severity, and the command enables none of the latched received flags as they stood before the message. The command bits are: bit 0 correctable, bit 1 non-fatal, bit 2 fatal. They map to status bits 0, 5 and 6.
- R7: In message mode, a command write pulses `irq_pulse_o` in the next cycle only when the new command enables a latched received flag and the old command enabled none.
- R8: `irq_level_o` is high exactly when `msi_enable_i` is low and the command enables a latched received flag. `irq_pulse_o` never follows a cycle with `msi_enable_i` low.
- R9: A status write (`wr_sel_i`=0) clears every bit among 6:0 where the data holds a one. It leaves the other bits of 6:0 and the vector field unchanged. A command write (`wr_sel_i`=1) loads `wr_data_i[2:0]` into the command.
- R10: `root_status_o[31:27]` follows `vec_num_i` with one cycle of latency.
- R11: If a status clear and a message arrive in the same cycle, the clear is applied first. The message is then evaluated against the cleared flags, so it still latches and can capture its ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | Error message present this cycle |
| msg_sev_i | input | 2 | Message severity code |
| msg_src_i | input | 16 | Requester ID of the message |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = status clear, 1 = command load |
| wr_data_i | input | 32 | Write data |
| msi_enable_i | input | 1 | Selects pulse (1) or level (0) notification |
| vec_num_i | input | 5 | Interrupt message number shown in status |
| root_cmd_o | output | 3 | Root error command enables |
| root_status_o | output | 32 | Root error status word |
| err_src_o | output | 32 | Captured source IDs (high uncorrectable, low correctable) |
| irq_level_o | output | 1 | Level interrupt |
| irq_pulse_o | output | 1 | One-cycle message-mode notification |

## Verification
The hardest condition to reach from the ports is the pulse-suppression rule. The outcome depends on how the history of earlier messages interacts with the current command. That history covers which flags are latched and whether the uncorrectable class was first set by a fatal or a non-fatal message. The bench therefore sweeps every three-message severity sequence against every command value, in both notification modes, and then rewrites the command to test the write-time pulse. Same-cycle clear-and-message collisions are set up directly by driving a status clear and a message on one edge.

// File: rtl/root_err_pkg.sv
package root_err_pkg;
  typedef enum logic [1:0] {
    SEV_COR      = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2,
    SEV_RSVD     = 2'd3
  } sev_e;

  localparam int RPT_W  = 7;
  localparam int CMD_W  = 3;
  localparam int B_COR  = 0;
  localparam int B_MCOR = 1;
  localparam int B_UNC  = 2;
  localparam int B_MUNC = 3;
  localparam int B_FFAT = 4;
  localparam int B_NF   = 5;
  localparam int B_FAT  = 6;

  function automatic logic [CMD_W-1:0] rcv_to_en(input logic [RPT_W-1:0] s);
    return {s[B_FAT], s[B_NF], s[B_COR]};
  endfunction

  function automatic logic [CMD_W-1:0] sev_to_en(input sev_e s);
    case (s)
      SEV_COR:      return 3'b001;
      SEV_NONFATAL: return 3'b010;
      SEV_FATAL:    return 3'b100;
      default:      return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/rerr_status_upd.sv
module rerr_status_upd
  import root_err_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic [RPT_W-1:0]   rpt_q_i,
  input  logic [RPT_W-1:0]   clr_i,
  input  logic               msg_valid_i,
  input  sev_e               sev_i,
  input  logic [SRC_W-1:0]   src_i,
  input  logic [2*SRC_W-1:0] src_q_i,
  output logic [RPT_W-1:0]   rpt_eff_o,
  output logic [RPT_W-1:0]   rpt_d_o,
  output logic [2*SRC_W-1:0] src_d_o
);
  logic is_unc;

  assign is_unc    = msg_valid_i && (sev_i == SEV_NONFATAL || sev_i == SEV_FATAL);
  // clear applies before the message is evaluated
  assign rpt_eff_o = rpt_q_i & ~clr_i;

  always_comb begin
    rpt_d_o = rpt_eff_o;
    src_d_o = src_q_i;
    if (msg_valid_i) begin
      case (sev_i)
        SEV_COR: begin
          if (rpt_eff_o[B_COR]) rpt_d_o[B_MCOR] = 1'b1;
          else                  src_d_o[SRC_W-1:0] = src_i;
          rpt_d_o[B_COR] = 1'b1;
        end
        SEV_NONFATAL: rpt_d_o[B_NF] = 1'b1;
        SEV_FATAL: begin
          if (!rpt_eff_o[B_UNC]) rpt_d_o[B_FFAT] = 1'b1;
          rpt_d_o[B_FAT] = 1'b1;
        end
        default: ;
      endcase
    end
    if (is_unc) begin
      if (rpt_eff_o[B_UNC]) rpt_d_o[B_MUNC] = 1'b1;
      else                  src_d_o[2*SRC_W-1:SRC_W] = src_i;
      rpt_d_o[B_UNC] = 1'b1;
    end
  end
endmodule

// File: rtl/rerr_notify.sv
module rerr_notify
  import root_err_pkg::*;
(
  input  logic             msi_i,
  input  logic             msg_valid_i,
  input  sev_e             sev_i,
  input  logic [RPT_W-1:0] rpt_eff_i,
  input  logic [RPT_W-1:0] rpt_q_i,
  input  logic [CMD_W-1:0] cmd_q_i,
  input  logic             cmd_wr_i,
  input  logic [CMD_W-1:0] cmd_new_i,
  output logic             pulse_d_o,
  output logic             level_o
);
  logic [CMD_W-1:0] en_prev, en_now;
  logic             msg_hit, wr_hit;

  assign en_prev = rcv_to_en(rpt_eff_i);
  assign en_now  = rcv_to_en(rpt_q_i);

  assign msg_hit = msg_valid_i && (|(cmd_q_i & sev_to_en(sev_i)))
                   && !(|(en_prev & cmd_q_i));
  assign wr_hit  = cmd_wr_i && (|(cmd_new_i & en_now)) && !(|(cmd_q_i & en_now));

  assign pulse_d_o = msi_i && (msg_hit || wr_hit);
  assign level_o   = !msi_i && (|(cmd_q_i & en_now));
endmodule

// File: rtl/root_err_collector.sv
module root_err_collector
  import root_err_pkg::*;
#(
  parameter int SRC_W  = 16,
  parameter int VEC_W  = 5,
  parameter int STAT_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               msg_valid_i,
  input  logic [1:0]         msg_sev_i,
  input  logic [SRC_W-1:0]   msg_src_i,
  input  logic               wr_en_i,
  input  logic               wr_sel_i,
  input  logic [STAT_W-1:0]  wr_data_i,
  input  logic               msi_enable_i,
  input  logic [VEC_W-1:0]   vec_num_i,
  output logic [CMD_W-1:0]   root_cmd_o,
  output logic [STAT_W-1:0]  root_status_o,
  output logic [2*SRC_W-1:0] err_src_o,
  output logic               irq_level_o,
  output logic               irq_pulse_o
);
  localparam int PAD_W = STAT_W - VEC_W - RPT_W;

  logic [RPT_W-1:0]   rpt_q, rpt_d, rpt_eff, clr;
  logic [2*SRC_W-1:0] src_q, src_d;
  logic [CMD_W-1:0]   cmd_q;
  logic [VEC_W-1:0]   vec_q;
  logic               pulse_q, pulse_d, cmd_wr;
  sev_e               sev;

  assign sev    = sev_e'(msg_sev_i);
  assign cmd_wr = wr_en_i && wr_sel_i;
  assign clr    = (wr_en_i && !wr_sel_i) ? wr_data_i[RPT_W-1:0] : '0;

  rerr_status_upd #(.SRC_W(SRC_W)) u_upd (
    .rpt_q_i     (rpt_q),
    .clr_i       (clr),
    .msg_valid_i (msg_valid_i),
    .sev_i       (sev),
    .src_i       (msg_src_i),
    .src_q_i     (src_q),
    .rpt_eff_o   (rpt_eff),
    .rpt_d_o     (rpt_d),
    .src_d_o     (src_d)
  );

  rerr_notify u_ntf (
    .msi_i       (msi_enable_i),
    .msg_valid_i (msg_valid_i),
    .sev_i       (sev),
    .rpt_eff_i   (rpt_eff),
    .rpt_q_i     (rpt_q),
    .cmd_q_i     (cmd_q),
    .cmd_wr_i    (cmd_wr),
    .cmd_new_i   (wr_data_i[CMD_W-1:0]),
    .pulse_d_o   (pulse_d),
    .level_o     (irq_level_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rpt_q   <= '0;
      src_q   <= '0;
      cmd_q   <= '0;
      vec_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      rpt_q   <= rpt_d;
      src_q   <= src_d;
      vec_q   <= vec_num_i;
      pulse_q <= pulse_d;
      if (cmd_wr) cmd_q <= wr_data_i[CMD_W-1:0];
    end
  end

  assign root_cmd_o    = cmd_q;
  assign root_status_o = {vec_q, {PAD_W{1'b0}}, rpt_q};
  assign err_src_o     = src_q;
  assign irq_pulse_o   = pulse_q;
endmodule

// File: rtl/root_err_collector_chk.sv
module root_err_collector_chk #(
  parameter int SRC_W  = 16,
  parameter int VEC_W  = 5,
  parameter int STAT_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               msg_valid_i,
  input logic [1:0]         msg_sev_i,
  input logic               wr_en_i,
  input logic               wr_sel_i,
  input logic [STAT_W-1:0]  wr_data_i,
  input logic               msi_enable_i,
  input logic [VEC_W-1:0]   vec_num_i,
  input logic [STAT_W-1:0]  root_status_o,
  input logic [2*SRC_W-1:0] err_src_o,
  input logic               irq_pulse_o
);
  // R2
  multi_cor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && msg_sev_i == 2'd0 && !wr_en_i && root_status_o[0])
    |=> (root_status_o[1] && $stable(err_src_o[SRC_W-1:0])));

  // R5
  multi_unc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && (msg_sev_i == 2'd1 || msg_sev_i == 2'd2) && !wr_en_i && root_status_o[2])
    |=> (root_status_o[3] && $stable(err_src_o[2*SRC_W-1:SRC_W])));

  // R4
  first_fatal_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && msg_sev_i == 2'd2 && !wr_en_i && root_status_o[2])
    |=> $stable(root_status_o[4]));

  // R8
  no_pulse_legacy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msi_enable_i |=> !irq_pulse_o);

  // R9
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i && wr_data_i[0] && !msg_valid_i) |=> !root_status_o[0]);

  // R10
  vec_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (root_status_o[STAT_W-1 -: VEC_W] == $past(vec_num_i)));
endmodule

bind root_err_collector root_err_collector_chk #(
  .SRC_W(SRC_W), .VEC_W(VEC_W), .STAT_W(STAT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .msg_valid_i  (msg_valid_i),
  .msg_sev_i    (msg_sev_i),
  .wr_en_i      (wr_en_i),
  .wr_sel_i     (wr_sel_i),
  .wr_data_i    (wr_data_i),
  .msi_enable_i (msi_enable_i),
  .vec_num_i    (vec_num_i),
  .root_status_o(root_status_o),
  .err_src_o    (err_src_o),
  .irq_pulse_o  (irq_pulse_o)
);

// File: tb/root_err_collector_bench.sv
module root_err_collector_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        msg_valid_i = 1'b0;
  logic [1:0]  msg_sev_i = 2'd0;
  logic [15:0] msg_src_i = 16'h0;
  logic        wr_en_i = 1'b0;
  logic        wr_sel_i = 1'b0;
  logic [31:0] wr_data_i = 32'h0;
  logic        msi_enable_i = 1'b0;
  logic [4:0]  vec_num_i = 5'h0;
  logic [2:0]  root_cmd_o;
  logic [31:0] root_status_o;
  logic [31:0] err_src_o;
  logic        irq_level_o;
  logic        irq_pulse_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state
  logic [6:0]  m_st = '0;
  logic [31:0] m_src = '0;
  logic [2:0]  m_cmd = '0;
  logic [4:0]  m_vec = '0;
  logic        m_pulse = 1'b0;
  logic [15:0] id_ctr = 16'h1000;

  always #10 clk_i = ~clk_i;

  root_err_collector u_root_err_collector (
    .clk_i, .rst_ni, .msg_valid_i, .msg_sev_i, .msg_src_i, .wr_en_i, .wr_sel_i,
    .wr_data_i, .msi_enable_i, .vec_num_i, .root_cmd_o, .root_status_o,
    .err_src_o, .irq_level_o, .irq_pulse_o
  );

  function automatic logic [2:0] en_of(input logic [6:0] s);
    return {s[6], s[5], s[0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " status"}, root_status_o, {m_vec, 20'h0, m_st});
    chk({req, " source"}, err_src_o, m_src);
    chk({req, " pulse"}, {31'h0, irq_pulse_o}, {31'h0, m_pulse});
    chk({req, " level"}, {31'h0, irq_level_o},
        {31'h0, !msi_enable_i && (|(m_cmd & en_of(m_st)))});
  endtask

  // applies the message to the model after the given clear mask
  task automatic model_msg(input int sev, input logic [15:0] id, input logic [6:0] clr);
    logic [6:0] e;
    e = m_st & ~clr;
    m_pulse = msi_enable_i && m_cmd[sev] && ((en_of(e) & m_cmd) == 3'b0);
    if (sev == 0) begin
      if (e[0]) e[1] = 1'b1; else m_src[15:0] = id;
      e[0] = 1'b1;
    end else begin
      if (sev == 1) e[5] = 1'b1;
      else begin
        if (!e[2]) e[4] = 1'b1;
        e[6] = 1'b1;
      end
      if (e[2]) e[3] = 1'b1; else m_src[31:16] = id;
      e[2] = 1'b1;
    end
    m_st = e;
  endtask

  task automatic send(input int sev, input string req);
    @(negedge clk_i);
    id_ctr = id_ctr + 16'h0101;
    msg_valid_i = 1'b1; msg_sev_i = sev[1:0]; msg_src_i = id_ctr;
    model_msg(sev, id_ctr, 7'h0);
    @(negedge clk_i);
    msg_valid_i = 1'b0;
    check_all(req);
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    m_pulse = 1'b0;
    if (sel) begin
      m_pulse = msi_enable_i && (|(d[2:0] & en_of(m_st))) && !(|(m_cmd & en_of(m_st)));
      m_cmd = d[2:0];
    end else m_st = m_st & ~d[6:0];
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 status", root_status_o, 32'h0);
    chk("R1 source", err_src_o, 32'h0);
    chk("R1 cmd", {29'h0, root_cmd_o}, 32'h0);
    chk("R1 irq", {30'h0, irq_level_o, irq_pulse_o}, 32'h0);
    rst_ni = 1'b1;

    // sweep: R2 R3 R4 R5 R6 R7 R8 over all 3-message sequences and commands
    for (int msi = 0; msi < 2; msi++) begin
      for (int c = 0; c < 8; c++) begin
        for (int seq = 0; seq < 27; seq++) begin
          msi_enable_i = msi[0];
          vec_num_i = 5'(seq + c);
          m_vec = vec_num_i;
          wr(1'b0, 32'h7f);
          wr(1'b1, 32'(c));
          chk("R9 cmd load", {29'h0, root_cmd_o}, 32'(c));
          send(seq % 3, "R2/R3/R4/R5/R6 msg1");
          send((seq / 3) % 3, "R2/R3/R4/R5/R6 msg2");
          send(seq / 9, "R2/R3/R4/R5/R6 msg3");
          wr(1'b1, 32'((c + 3) % 8));
          check_all("R7/R8 cmd write");
        end
      end
    end

    // R9: partial clear leaves other bits
    msi_enable_i = 1'b0;
    wr(1'b0, 32'h7f);
    wr(1'b1, 32'h0);
    send(0, "R2 setup");
    send(0, "R2 setup2");
    wr(1'b0, 32'h2);
    check_all("R9 partial clear");
    wr(1'b0, 32'h0);
    check_all("R9 zero write");
    wr(1'b0, 32'hffff_ff80);
    check_all("R9 upper bits ignored");

    // R10: vector follows input
    @(negedge clk_i);
    vec_num_i = 5'h15; m_vec = 5'h15;
    @(negedge clk_i);
    chk("R10 vector", {27'h0, root_status_o[31:27]}, 32'h15);

    // R11: same-cycle clear and message
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_data_i = 32'h03;
    msg_valid_i = 1'b1; msg_sev_i = 2'd0; msg_src_i = 16'hbeef;
    model_msg(0, 16'hbeef, 7'h03);
    @(negedge clk_i);
    wr_en_i = 1'b0; msg_valid_i = 1'b0;
    check_all("R11 clear+msg");
    chk("R11 src", {16'h0, err_src_o[15:0]}, 32'hbeef);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule